// File: doc/BRIEF.md
# Generalized bit-reverse permutation unit

This block reorders the bits of a 32-bit word. Each bit moves to the position whose index equals its own index XOR-ed with a 5-bit control value. A control value of zero leaves the word as it is. A single set control bit swaps neighbouring groups of one size. All ones reverses the whole word.

The permutation network has five conditional swap layers, one per control bit. Each layer exchanges adjacent groups of 1, 2, 4, 8 or 16 bits. The layers are applied in ascending order of control bit.

The network is combinational, followed by one output register. A result is registered on the clock edge that samples the valid strobe high, so the result and its valid flag appear one cycle later. On cycles without a strobe, the registered word is held.

Top module: `grev_unit`

## Requirements
- R1: Only bits [4:0] of `ctrl_i` select the permutation; bits [31:5] have no effect on `data_o`.
- R2: For every index i, the result bit i equals input bit (i XOR k), where k = `ctrl_i[4:0]`.
- R3: With k = 0 the result equals the input word.
- R4: With k = 31 the result is the input word with its bit order fully reversed (bit 0 goes to bit 31).
- R5: Permuting a result a second time with the same k returns the original word, and every result has the same number of set bits as its input.
- R6: `valid_o` equals `valid_i` delayed by one clock; each strobe yields exactly one result, in order.
- R7: When `valid_i` is low at a clock edge, `data_o` keeps its previous value.
- R8: While `rst_ni` is low, `valid_o` and `data_o` are 0, independent of the clock.
- R9: With k = 2^j (j = 0..4), each aligned pair of 2^j-bit groups is exchanged and nothing else moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| data_i | input | 32 | Word to permute |
| ctrl_i | input | 32 | Control operand; only bits [4:0] are used |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| data_o | output | 32 | Registered permuted word |

## Verification
Assertions check the following on every clock:
- the one-cycle valid delay;
- hold of `data_o` when no strobe arrives;
- pass-through at k = 0 and full reversal at k = 31;
- preservation of the number of set bits through the network.

Only the bench scenarios can show the rest:
- the exact index mapping for arbitrary k;
- the independence from the upper control bits;
- the involution over pairs of strobes;
- the in-order, one-to-one pairing of strobes and results under bubbles;
- the asynchronous clearing by a reset issued mid-stream.

// File: rtl/grev_pkg.sv
package grev_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 32;
  localparam int unsigned CTRL_W = $clog2(DATA_W);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CTRL_W-1:0] sel_t;

  // bit i set when bit 'level' of index i is zero (lower group of each pair)
  function automatic word_t lower_mask(int unsigned level);
    word_t m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i >> level) & 1) == 0;
    return m;
  endfunction

  function automatic word_t reverse_word(word_t w);
    word_t r;
    for (int i = 0; i < DATA_W; i++) r[i] = w[DATA_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/grev_stage.sv
module grev_stage
  import grev_pkg::*;
#(
  parameter int unsigned LEVEL = 0
) (
  input  logic  swap_i,
  input  word_t data_i,
  output word_t data_o
);
  localparam int unsigned SHIFT = 1 << LEVEL;
  localparam word_t       LO_M  = lower_mask(LEVEL);
  localparam word_t       HI_M  = ~LO_M;

  word_t swapped;

  always_comb begin
    swapped = ((data_i & LO_M) << SHIFT) | ((data_i & HI_M) >> SHIFT);
    data_o  = swap_i ? swapped : data_i;
  end
endmodule

// File: rtl/grev_net.sv
module grev_net
  import grev_pkg::*;
(
  input  sel_t  sel_i,
  input  word_t data_i,
  output word_t data_o
);
  word_t lvl [CTRL_W+1];

  assign lvl[0] = data_i;

  // ascending order of control bit
  for (genvar g = 0; g < CTRL_W; g++) begin : g_stage
    grev_stage #(.LEVEL(g)) u_stage (
      .swap_i (sel_i[g]),
      .data_i (lvl[g]),
      .data_o (lvl[g+1])
    );
  end

  assign data_o = lvl[CTRL_W];
endmodule

// File: rtl/grev_unit.sv
module grev_unit
  import grev_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [OP_W-1:0]   ctrl_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  sel_t  sel;
  word_t perm;
  word_t data_q;
  logic  valid_q;

  assign sel = ctrl_i[CTRL_W-1:0];  // upper operand bits unused

  grev_net u_net (
    .sel_i  (sel),
    .data_i (data_i),
    .data_o (perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) data_q <= perm;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  a_r6_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r6_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  a_r3_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel == '0) |=> data_o == $past(data_i));
  a_r4_reverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel == '1) |=> data_o == reverse_word($past(data_i)));
  a_r5_weight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> $countones(data_o) == $countones($past(data_i)));
endmodule

// File: tb/grev_unit_bench.sv
module grev_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] ctrl_i = '0;
  logic        valid_o;
  logic [31:0] data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] last_exp = '0;

  always #5 clk_i = ~clk_i;

  grev_unit u_grev_unit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .ctrl_i  (ctrl_i),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  function automatic logic [31:0] model(logic [31:0] d, logic [4:0] k);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = d[i ^ int'(k)];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one strobe per call, expected value pushed to the scoreboard
  task automatic drive(logic [31:0] d, logic [31:0] c, logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk_i);
    valid_i = 1'b1;
    data_i  = d;
    ctrl_i  = c;
    it.exp  = exp;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      data_i  = $urandom;
      ctrl_i  = $urandom;
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sb_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R6 actual valid_o=1 expected 0 (no pending strobe)");
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, data_o, it.exp);
        last_exp = it.exp;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c, y;
    logic [31:0] upd;
    // R8: reset state
    repeat (3) @(negedge clk_i);
    check("R8 valid_o in reset", {31'b0, valid_o}, 32'h0);
    check("R8 data_o in reset", data_o, 32'h0);
    rst_ni = 1'b1;
    idle(2);
    check("R6 valid_o idle after reset", {31'b0, valid_o}, 32'h0);

    // R3: zero control
    drive(32'hDEADBEEF, 32'h0, 32'hDEADBEEF, "R3");
    drive(32'h00000001, 32'h0, 32'h00000001, "R3");
    drive(32'h80000000, 32'h0, 32'h80000000, "R3");

    // R4: full reversal
    drive(32'h00000001, 32'd31, 32'h80000000, "R4");
    drive(32'h12345678, 32'd31, 32'h1E6A2C48, "R4");
    drive(32'hF0000000, 32'd31, 32'h0000000F, "R4");

    // R9: single control bit, hand-derived values
    drive(32'h00000001, 32'd1,  32'h00000002, "R9");
    drive(32'h00000003, 32'd2,  32'h0000000C, "R9");
    drive(32'h0000000F, 32'd4,  32'h000000F0, "R9");
    drive(32'h000000FF, 32'd8,  32'h0000FF00, "R9");
    drive(32'h0000FFFF, 32'd16, 32'hFFFF0000, "R9");
    drive(32'h12345678, 32'd16, 32'h56781234, "R9");
    drive(32'h12345678, 32'd4,  32'h21436587, "R9");

    // R2: every k, random data, with bubbles (R6)
    for (int k = 0; k < 32; k++) begin
      d = $urandom;
      drive(d, k, model(d, k[4:0]), "R2");
      if (k % 5 == 2) idle(1 + k % 3);
    end

    // R1: upper control bits set
    for (int i = 0; i < 16; i++) begin
      d   = $urandom;
      c   = $urandom;
      upd = {c[31:5] | 27'h1, c[4:0]};
      drive(d, upd, model(d, c[4:0]), "R1");
    end

    // R5: involution, second pass must return the original
    for (int i = 0; i < 24; i++) begin
      d = $urandom;
      c = $urandom;
      y = model(d, c[4:0]);
      drive(d, c, y, "R5 first pass");
      drive(y, c, d, "R5 second pass");
    end
    for (int i = 0; i < 8; i++) begin
      idle(1);
      check("R5 weight", $countones(data_o), $countones(last_exp));
    end

    // R7: hold under changing idle inputs
    idle(3);
    check("R6 queue drained", sb_q.size(), 0);
    check("R6 valid_o low when idle", {31'b0, valid_o}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      idle(1);
      check("R7 data_o held", data_o, last_exp);
    end

    // R8: asynchronous reset mid-stream
    drive(32'hA5A5A5A5, 32'd0, 32'hA5A5A5A5, "R3");
    idle(1);
    drive(32'h0F0F0F0F, 32'd3, model(32'h0F0F0F0F, 5'd3), "R2");
    @(posedge clk_i);
    #2;
    rst_ni = 1'b0;
    sb_q.delete();
    #1;
    check("R8 valid_o async clear", {31'b0, valid_o}, 32'h0);
    check("R8 data_o async clear", data_o, 32'h0);
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);
    check("R8 idle after reset", {31'b0, valid_o}, 32'h0);
    drive(32'h00000001, 32'hFFFFFFE0, 32'h00000001, "R1");
    idle(3);
    check("R6 final queue drained", sb_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule